// File: doc/BRIEF.md
# Banked Program Memory Mapper with Nibble Table Reader

This block sits between a 4-bit controller core and a 32K x 8 program memory organised as eight 4 KB banks. A 13-bit program counter addresses an 8 KB window: its lower half always lands in bank 0. Its upper half lands in a bank chosen by a 3-bit select register, offset by one. A select of 0 therefore reaches bank 1, and a select of 1 reaches bank 2.

The block also holds a 12-bit table pointer. It is loaded one nibble at a time and lets software read constants stored in the switchable window, four bits per access. A low read returns the lower nibble of the addressed byte and leaves the pointer unchanged. A high read returns the upper nibble and advances the pointer. A sequence of one low read and one high read therefore walks through a byte table.

The memory array itself lies outside the block. The block drives two physical addresses, one for instruction fetch and one for table reads, and takes back the table byte.

Top module: `rom_table_reader`

## Requirements
- R1: When pc_i bit 12 is 0, fetch_addr_o equals {3'b000, pc_i[11:0]}, combinationally.
- R2: When pc_i bit 12 is 1, fetch_addr_o equals {(sel + 1) mod 8, pc_i[11:0]}, where sel is the bank-select register. A select of 0 reaches bank 1, and a select of 7 wraps to bank 0.
- R3: After rst_ni is released, the bank select is 0, the table pointer is 000h and nib_o is 0h. In this state, pc_i = 1000h gives fetch_addr_o = 1000h and tbl_addr_o = 1000h.
- R4: A cycle with bank_we_i high loads bank_sel_i into the select register. The new value affects both address outputs from the following cycle.
- R5: Each ptr_ld_i bit writes ptr_nib_i into one pointer nibble, effective in the following cycle: bit 0 writes pointer bits 3..0, bit 1 writes bits 7..4, and bit 2 writes bits 11..8. Nibbles whose strobe is low keep their value.
- R6: tbl_addr_o equals {(sel + 1) mod 8, pointer}, combinationally.
- R7: A cycle with rd_lo_i high and rd_hi_i low captures tbl_byte_i[3:0] into nib_o, visible from the next cycle, and leaves the pointer unchanged.
- R8: A cycle with rd_hi_i high captures tbl_byte_i[7:4] into nib_o and increments the pointer by one, wrapping from FFFh to 000h. It takes priority when rd_lo_i is also high.
- R9: If any ptr_ld_i bit is high in a high-read cycle, the increment is dropped and only the loaded nibbles change. In a cycle with no read request, nib_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 13 | Program counter |
| fetch_addr_o | output | 15 | Physical fetch address |
| bank_we_i | input | 1 | Bank-select write strobe |
| bank_sel_i | input | 3 | Bank-select write data |
| ptr_ld_i | input | 3 | Pointer nibble load strobes (bit n loads nibble n) |
| ptr_nib_i | input | 4 | Pointer nibble load data |
| rd_lo_i | input | 1 | Low-nibble table read request |
| rd_hi_i | input | 1 | High-nibble table read request with pointer advance |
| tbl_addr_o | output | 15 | Physical table-read address |
| tbl_byte_i | input | 8 | Byte returned from tbl_addr_o |
| nib_o | output | 4 | Registered nibble result |

## Verification
The assertions check on every cycle that:
- the lower PC window never leaves bank 0;
- the pointer holds across low reads;
- the pointer advances by exactly one across high reads without loads;
- nib_o takes the selected nibble of the byte presented at the read edge.

The +1 bank offset and its wrap at select 7 can only be shown by the bench's scenarios. The same holds for the pointer wrap at FFFh, the load-over-increment priority, and the end-to-end byte at 1777h splitting into 6h and 5h. These are checked against a computed memory image across every select value.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  parameter int RTR_OFF_W  = 12;
  parameter int RTR_BANK_W = 3;
  parameter int RTR_NIB_W  = 4;

  typedef enum logic [1:0] {RD_NONE, RD_LO, RD_HI} rd_kind_e;
endpackage

// File: rtl/rtr_bank_map.sv
module rtr_bank_map #(
  parameter int OFF_W  = 12,
  parameter int BANK_W = 3,
  localparam int PHYS_W = OFF_W + BANK_W
) (
  input  logic              win_hi_i,
  input  logic [BANK_W-1:0] sel_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [PHYS_W-1:0] addr_o
);
  logic [BANK_W-1:0] bank;
  // switchable window sits one bank above the select value
  always_comb begin
    bank   = win_hi_i ? BANK_W'(sel_i + 1'b1) : '0;
    addr_o = {bank, off_i};
  end
endmodule

// File: rtl/rtr_tbl_ptr.sv
module rtr_tbl_ptr #(
  parameter int OFF_W = 12,
  parameter int NIB_W = 4,
  localparam int NUM_NIB = OFF_W / NIB_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_NIB-1:0] ld_i,
  input  logic [NIB_W-1:0]   nib_i,
  input  logic               inc_i,
  output logic [OFF_W-1:0]   ptr_o
);
  logic [OFF_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (|ld_i) begin
      for (int i = 0; i < NUM_NIB; i++)
        if (ld_i[i]) ptr_q[i*NIB_W +: NIB_W] <= nib_i;
    end else if (inc_i) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr_o = ptr_q;

  assert_ptr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && ld_i == '0) |=> ptr_q == $past(ptr_q));
  assert_ptr_inc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && ld_i == '0) |=> ptr_q == OFF_W'($past(ptr_q) + 1'b1));
endmodule

// File: rtl/rtr_nib_sel.sv
module rtr_nib_sel
  import rtr_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rd_kind_e          kind_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [NIB_W-1:0]  nib_o
);
  logic [NIB_W-1:0] nib_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nib_q <= '0;
    else begin
      unique case (kind_i)
        RD_HI:   nib_q <= byte_i[BYTE_W-1:NIB_W];
        RD_LO:   nib_q <= byte_i[NIB_W-1:0];
        default: nib_q <= nib_q;
      endcase
    end
  end

  assign nib_o = nib_q;

  assert_nib_lo_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_i == RD_LO |=> nib_q == $past(byte_i[NIB_W-1:0]));
  assert_nib_hi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_i == RD_HI |=> nib_q == $past(byte_i[BYTE_W-1:NIB_W]));
  assert_nib_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_i == RD_NONE |=> $stable(nib_q));
endmodule

// File: rtl/rom_table_reader.sv
module rom_table_reader
  import rtr_pkg::*;
#(
  parameter int OFF_W  = RTR_OFF_W,
  parameter int BANK_W = RTR_BANK_W,
  parameter int NIB_W  = RTR_NIB_W,
  localparam int PC_W    = OFF_W + 1,
  localparam int PHYS_W  = OFF_W + BANK_W,
  localparam int BYTE_W  = 2 * NIB_W,
  localparam int NUM_NIB = OFF_W / NIB_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PC_W-1:0]    pc_i,
  output logic [PHYS_W-1:0]  fetch_addr_o,
  input  logic               bank_we_i,
  input  logic [BANK_W-1:0]  bank_sel_i,
  input  logic [NUM_NIB-1:0] ptr_ld_i,
  input  logic [NIB_W-1:0]   ptr_nib_i,
  input  logic               rd_lo_i,
  input  logic               rd_hi_i,
  output logic [PHYS_W-1:0]  tbl_addr_o,
  input  logic [BYTE_W-1:0]  tbl_byte_i,
  output logic [NIB_W-1:0]   nib_o
);
  logic [BANK_W-1:0] sel_q;
  logic [OFF_W-1:0]  ptr;
  rd_kind_e          kind;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sel_q <= '0;
    else if (bank_we_i) sel_q <= bank_sel_i;
  end

  always_comb begin
    if (rd_hi_i)      kind = RD_HI;
    else if (rd_lo_i) kind = RD_LO;
    else              kind = RD_NONE;
  end

  rtr_bank_map #(.OFF_W(OFF_W), .BANK_W(BANK_W)) u_fetch_map (
    .win_hi_i (pc_i[PC_W-1]),
    .sel_i    (sel_q),
    .off_i    (pc_i[OFF_W-1:0]),
    .addr_o   (fetch_addr_o)
  );

  rtr_bank_map #(.OFF_W(OFF_W), .BANK_W(BANK_W)) u_tbl_map (
    .win_hi_i (1'b1),
    .sel_i    (sel_q),
    .off_i    (ptr),
    .addr_o   (tbl_addr_o)
  );

  rtr_tbl_ptr #(.OFF_W(OFF_W), .NIB_W(NIB_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (ptr_ld_i),
    .nib_i  (ptr_nib_i),
    .inc_i  (rd_hi_i),
    .ptr_o  (ptr)
  );

  rtr_nib_sel #(.NIB_W(NIB_W)) u_nib (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kind_i (kind),
    .byte_i (tbl_byte_i),
    .nib_o  (nib_o)
  );

  assert_lower_bank0_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_i[PC_W-1] |-> fetch_addr_o[PHYS_W-1:OFF_W] == '0);
  assert_sel_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_we_i |=> sel_q == $past(bank_sel_i));
  assert_upper_same_bank_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_i[PC_W-1] |-> fetch_addr_o[PHYS_W-1:OFF_W] == tbl_addr_o[PHYS_W-1:OFF_W]);
endmodule

// File: tb/rom_table_reader_tb.sv
module rom_table_reader_tb;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [12:0] pc;
  logic [14:0] fetch_addr;
  logic        bank_we;
  logic [2:0]  bank_sel;
  logic [2:0]  ptr_ld;
  logic [3:0]  ptr_nib;
  logic        rd_lo, rd_hi;
  logic [14:0] tbl_addr;
  logic [7:0]  tbl_byte;
  logic [3:0]  nib;

  int checks = 0;
  int errors = 0;
  logic [2:0]  m_sel;
  logic [11:0] m_ptr;

  always #2 clk = ~clk;

  rom_table_reader u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pc_i(pc), .fetch_addr_o(fetch_addr),
    .bank_we_i(bank_we), .bank_sel_i(bank_sel), .ptr_ld_i(ptr_ld),
    .ptr_nib_i(ptr_nib), .rd_lo_i(rd_lo), .rd_hi_i(rd_hi),
    .tbl_addr_o(tbl_addr), .tbl_byte_i(tbl_byte), .nib_o(nib)
  );

  function automatic logic [7:0] rom_f(input logic [14:0] a);
    if (a == 15'h1777) return 8'h56;
    return a[7:0] ^ {a[11:8], 1'b0, a[14:12]} ^ 8'h3C;
  endfunction

  always_comb tbl_byte = rom_f(tbl_addr);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_bank(input logic [2:0] v);
    bank_we = 1'b1; bank_sel = v;
    tick();
    bank_we = 1'b0;
    m_sel = v;
  endtask

  task automatic ld_ptr(input logic [11:0] v);
    for (int i = 0; i < 3; i++) begin
      ptr_ld = 3'(1 << i); ptr_nib = v[i*4 +: 4];
      tick();
    end
    ptr_ld = '0;
    m_ptr = v;
  endtask

  function automatic logic [14:0] exp_tbl();
    return {3'(m_sel + 3'd1), m_ptr};
  endfunction

  task automatic rd(input logic lo, input logic hi);
    logic [7:0] b;
    b = rom_f(exp_tbl());
    rd_lo = lo; rd_hi = hi;
    tick();
    rd_lo = 1'b0; rd_hi = 1'b0;
    if (hi) begin
      chk("R8 high nibble", nib, b[7:4]);
      m_ptr = m_ptr + 12'd1;
    end else begin
      chk("R7 low nibble", nib, b[3:0]);
    end
    chk(hi ? "R8 pointer after high read" : "R7 pointer kept", tbl_addr, exp_tbl());
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; pc = '0; bank_we = 0; bank_sel = '0; ptr_ld = '0;
    ptr_nib = '0; rd_lo = 0; rd_hi = 0; m_sel = '0; m_ptr = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    pc = 13'h1000; #1;
    chk("R3 reset nib", nib, 0);
    chk("R3 reset fetch", fetch_addr, 15'h1000);
    chk("R3 reset table addr", tbl_addr, 15'h1000);

    // R1 R2 R4: sweep every select and spread of PC values
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      wr_bank(3'(s));
      for (int p = 0; p < 13'h2000; p += 13'h0FD) begin
        pc = 13'(p); #1;
        if (p < 13'h1000) chk("R1 lower window", fetch_addr, {3'b000, pc[11:0]});
        else chk("R2 upper window", fetch_addr, {3'(s + 1), pc[11:0]});
      end
      pc = 13'h1FFF; #1;
      chk("R2 upper edge", fetch_addr, {3'(s + 1), 12'hFFF});
      pc = 13'h0FFF; #1;
      chk("R1 lower edge", fetch_addr, {3'b000, 12'hFFF});
      chk("R6 table addr", tbl_addr, exp_tbl());
    end

    // byte 56h at 1777h with select 0
    wr_bank(3'd0);
    ld_ptr(12'h777);
    chk("R5 pointer load", tbl_addr, 15'h1777);
    rd(1'b1, 1'b0);
    chk("R7 example low", nib, 4'h6);
    rd(1'b0, 1'b1);
    chk("R8 example high", nib, 4'h5);
    chk("R8 example advance", tbl_addr, 15'h1778);

    // R9 hold with no request
    tick();
    chk("R9 nib hold", nib, 4'h5);

    // R8 wrap
    ld_ptr(12'hFFF);
    rd(1'b0, 1'b1);
    chk("R8 wrap", tbl_addr, {3'd1, 12'h000});

    // R8 both requests: high wins
    ld_ptr(12'h3A5);
    rd(1'b1, 1'b1);

    // R9 load beats increment; other nibbles kept (R5)
    ld_ptr(12'h4B6);
    ptr_ld = 3'b001; ptr_nib = 4'hC; rd_hi = 1'b1;
    tick();
    ptr_ld = '0; rd_hi = 1'b0;
    m_ptr = 12'h4BC;
    chk("R9 load over increment", tbl_addr, exp_tbl());
    ptr_ld = 3'b100; ptr_nib = 4'h9;
    tick();
    ptr_ld = '0; m_ptr = 12'h9BC;
    chk("R5 high nibble only", tbl_addr, exp_tbl());

    // table walk in every bank
    for (int s = 0; s < 8; s++) begin
      wr_bank(3'(s));
      ld_ptr(12'(s * 12'h1F3 + 12'h0FE));
      for (int k = 0; k < 4; k++) begin
        rd(1'b1, 1'b0);
        rd(1'b0, 1'b1);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule